// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Ratio-Change Acknowledge

This block divides a fast source clock by an integer ratio from 1 to 31. It does not generate a new clock net. It produces a clock-enable pulse train on the source clock: the pulse is high for one source cycle out of every N. A 5-bit ratio is written through a strobe. A write is held pending and takes effect only when the current output period ends, so the pulse spacing never shrinks part-way through a period. Each time a pending ratio takes effect, an acknowledge bit toggles. Software can poll that bit to learn when its change has landed.

The output runs in one of two ways. In automatic mode it runs only while some consumer asserts the request input. In forced mode it runs regardless of requests. A power-down control shuts the divider off, but only once the output has already stopped. A power-down asked for while pulses are flowing stays pending until the output gates. The block has three states: `GS_OFF` (powered down), `GS_GATED` (idle, counter cleared) and `GS_RUN` (pulses produced).

The state transitions are:
- `GS_GATED -> GS_RUN` when there is demand and no power-down.
- `GS_RUN -> GS_GATED` when the demand is gone.
- `GS_GATED -> GS_OFF` when power-down is set.
- `GS_OFF -> GS_GATED` when power-down is cleared.

There is no direct path from `GS_RUN` to `GS_OFF`.

Top module: `clkdiv_post`

## Requirements
- R1: After reset the ratio is 1, the output is gated (`st_running_o`=0, `clk_en_o`=0) and `div_ack_o` is 0.
- R2: While running with ratio N, `clk_en_o` is high for one cycle in every N source cycles. With N=1 it is high on every running cycle. After the block enters `GS_RUN`, the first pulse appears in the N-th running cycle.
- R3: A write with `cfg_div`=0 is ignored: the ratio in use and any pending ratio are kept.
- R4: While running, a written ratio takes effect only at the edge that ends the current period (the cycle of an enable pulse). The next period is then counted with the new ratio from zero.
- R5: `div_ack_o` toggles exactly once per ratio that takes effect, in the cycle it takes effect. If a second non-zero write arrives before the first is applied, it replaces the first, and only one toggle follows.
- R6: With `cfg_gate_force`=0, the output runs only while `clk_req` is 1. When `clk_req` drops, the block leaves the running state at the next edge.
- R7: With `cfg_gate_force`=1, the output runs whatever the value of `clk_req`.
- R8: `st_running_o` is 1 exactly while the block is in the running state, and 0 while it is gated or powered down.
- R9: `cfg_pwdn` set while running has no effect on the pulses. The block powers down only after it has gated.
- R10: While powered down, `clk_en_o` stays 0 and demand does not restart the output. After `cfg_pwdn` clears, the block passes through the gated state, and counting restarts from zero.
- R11: While the output is not running, a written ratio takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the ratio field |
| cfg_div | input | 5 | Ratio to write; 0 is reserved and ignored |
| cfg_gate_force | input | 1 | 1 keeps the output running; 0 selects automatic gating |
| cfg_pwdn | input | 1 | Power-down request, honoured only when gated |
| clk_req | input | 1 | Consumer request for the divided clock |
| clk_en_o | output | 1 | Divided clock as a one-cycle enable pulse train |
| st_running_o | output | 1 | 1 while running, 0 while gated or off |
| div_ack_o | output | 1 | Toggles when a new ratio takes effect |

## Verification
The collision that matters is a pending ratio being applied at a period boundary in the same cycle that a fresh write arrives. In that cycle the old pending value must take effect and toggle the acknowledge, and the new value must stay queued for the next boundary. The bench provokes this by timing a second write onto a pulse cycle. It also writes twice inside one long period, and drops the request on a pulse edge. A cycle-accurate expectation model, built from the requirements, queues the expected enable, status and acknowledge for every cycle. A monitor compares each queued item against the ports.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned DIV_W_DEF = 5;

    typedef enum logic [1:0] {
        GS_OFF   = 2'd0,
        GS_GATED = 2'd1,
        GS_RUN   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/clkdiv_gate_fsm.sv
module clkdiv_gate_fsm
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic pwdn_i,
    output logic running_o,
    output logic off_o
);
    gate_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OFF:   if (!pwdn_i) state_d = GS_GATED;
            GS_GATED: begin
                if (pwdn_i)      state_d = GS_OFF;
                else if (want_i) state_d = GS_RUN;
            end
            GS_RUN:   if (!want_i) state_d = GS_GATED;
            default:  state_d = GS_GATED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_GATED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        running_o = 1'b0;
        off_o     = 1'b0;
        unique case (state_q)
            GS_RUN:  running_o = 1'b1;
            GS_OFF:  off_o     = 1'b1;
            default: ;
        endcase
    end

    // R9: power-down never cuts a running output directly
    a_r9_no_off_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN) |=> (state_q != GS_OFF));

    // R6: without demand the running state is left at the next edge
    a_r6_leave_run_without_demand: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN && !want_i) |=> (state_q == GS_GATED));
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             at_end_o
);
    logic [DIV_W-1:0] cnt_q;

    assign at_end_o = run_i && (cnt_q == ratio_i - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run_i)   cnt_q <= '0;
        else if (at_end_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + DIV_W'(1);
    end

    // R2: while running the phase never reaches the ratio
    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < ratio_i));

    // R10: after any idle cycle counting starts from zero
    a_r10_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_ratio_ctl.sv
module clkdiv_ratio_ctl #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             running_i,
    input  logic             at_end_i,
    output logic [DIV_W-1:0] ratio_o,
    output logic             ack_o
);
    logic [DIV_W-1:0] pend_q, cur_q;
    logic             pend_vld_q, ack_q;
    logic             wr_ok, apply;

    assign wr_ok   = wr_i && (div_i != '0);
    assign apply   = pend_vld_q && (!running_i || at_end_i);
    assign ratio_o = cur_q;
    assign ack_o   = ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= DIV_W'(1);
            pend_q     <= DIV_W'(1);
            pend_vld_q <= 1'b0;
            ack_q      <= 1'b0;
        end else begin
            if (apply) begin
                cur_q <= pend_q;
                ack_q <= ~ack_q;
            end
            if (wr_ok) begin
                pend_q     <= div_i;
                pend_vld_q <= 1'b1;
            end else if (apply) begin
                pend_vld_q <= 1'b0;
            end
        end
    end

    // R3: the ratio in use is never the reserved value
    a_r3_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q != '0);

    // R4: a running ratio only changes on a period end
    a_r4_change_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> $past(!running_i || at_end_i));

    // R5: the acknowledge only moves when a pending ratio existed
    a_r5_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != $past(ack_q)) |-> $past(pend_vld_q));
endmodule

// File: rtl/clkdiv_post.sv
module clkdiv_post #(
    parameter int unsigned DIV_W = clkdiv_pkg::DIV_W_DEF
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_gate_force,
    input  logic             cfg_pwdn,
    input  logic             clk_req,
    output logic             clk_en_o,
    output logic             st_running_o,
    output logic             div_ack_o
);
    logic             want, running, off, at_end;
    logic [DIV_W-1:0] ratio;

    assign want = cfg_gate_force | clk_req;

    clkdiv_gate_fsm u_fsm (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .want_i    (want),
        .pwdn_i    (cfg_pwdn),
        .running_o (running),
        .off_o     (off)
    );

    clkdiv_count #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .run_i    (running),
        .ratio_i  (ratio),
        .at_end_o (at_end)
    );

    clkdiv_ratio_ctl #(.DIV_W(DIV_W)) u_ratio (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr),
        .div_i     (cfg_div),
        .running_i (running),
        .at_end_i  (at_end),
        .ratio_o   (ratio),
        .ack_o     (div_ack_o)
    );

    assign clk_en_o     = at_end;
    assign st_running_o = running;

    // R10: a powered-down divider is silent
    a_r10_off_silent: assert property (@(posedge clk_src) disable iff (!rst_n)
        off |-> !clk_en_o);

    // R8: pulses only while the status reports running
    a_r8_pulse_needs_running: assert property (@(posedge clk_src) disable iff (!rst_n)
        clk_en_o |-> st_running_o);
endmodule

// File: tb/clkdiv_post_tb.sv
module clkdiv_post_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk_src = 1'b0;
    logic       rst_n   = 1'b0;
    logic       cfg_wr = 1'b0, cfg_gate_force = 1'b0, cfg_pwdn = 1'b0, clk_req = 1'b0;
    logic [4:0] cfg_div = 5'd0;
    logic       clk_en_o, st_running_o, div_ack_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk_src = ~clk_src;

    clkdiv_post u_dut (
        .clk_src(clk_src), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .cfg_gate_force(cfg_gate_force), .cfg_pwdn(cfg_pwdn), .clk_req(clk_req),
        .clk_en_o(clk_en_o), .st_running_o(st_running_o), .div_ack_o(div_ack_o)
    );

    typedef struct {
        logic  en;
        logic  run;
        logic  ack;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    // expectation model state: 0 off, 1 gated, 2 running
    int         m_st   = 1;
    int         m_cnt  = 0;
    logic [4:0] m_cur  = 5'd1;
    logic [4:0] m_pend = 5'd1;
    bit         m_pv   = 1'b0;
    bit         m_ack  = 1'b0;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: pops one expectation per cycle, away from the active edge
    always @(negedge clk_src) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " clk_en_o"}, clk_en_o, e.en);
            check("R8 st_running_o", st_running_o, e.run);
            check("R5 div_ack_o", div_ack_o, e.ack);
        end
    end

    // driver: applies one cycle of inputs and pushes the expected outcome
    task automatic tick(input string tag, input bit wr, input logic [4:0] dv,
                        input bit force_on, input bit pd, input bit req);
        bit want, running, at_end, apply;
        exp_t e;
        cfg_wr = wr; cfg_div = dv; cfg_gate_force = force_on; cfg_pwdn = pd; clk_req = req;
        want    = force_on | req;
        running = (m_st == 2);
        at_end  = running && (m_cnt == int'(m_cur) - 1);
        apply   = m_pv && (!running || at_end);
        if (!running || at_end) m_cnt = 0; else m_cnt++;
        if (apply) begin m_cur = m_pend; m_ack = !m_ack; end
        if (wr && dv != 5'd0) begin m_pend = dv; m_pv = 1'b1; end
        else if (apply) m_pv = 1'b0;
        case (m_st)
            0: if (!pd) m_st = 1;
            1: if (pd) m_st = 0; else if (want) m_st = 2;
            default: if (!want) m_st = 1;
        endcase
        e.en  = (m_st == 2) && (m_cnt == int'(m_cur) - 1);
        e.run = (m_st == 2);
        e.ack = m_ack;
        e.tag = tag;
        @(posedge clk_src);
        #1 sb_q.push_back(e);
        @(negedge clk_src);
    endtask

    task automatic run_n(input string tag, input int n, input bit force_on,
                         input bit pd, input bit req);
        for (int i = 0; i < n; i++) tick(tag, 1'b0, 5'd0, force_on, pd, req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_src);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 clk_en_o", clk_en_o, 1'b0);
        check("R1 st_running_o", st_running_o, 1'b0);
        check("R1 div_ack_o", div_ack_o, 1'b0);
        run_n("R1", 3, 0, 0, 0);
        // R2 ratio 1: every running cycle
        run_n("R2", 6, 0, 0, 1);
        // R4 write 3 while running, applied at a boundary
        tick("R4", 1'b1, 5'd3, 0, 0, 1);
        run_n("R4", 12, 0, 0, 1);
        // R3 reserved value ignored
        tick("R3", 1'b1, 5'd0, 0, 0, 1);
        run_n("R3", 8, 0, 0, 1);
        // R5 two writes inside one period, one toggle
        tick("R5", 1'b1, 5'd5, 0, 0, 1);
        tick("R5", 1'b1, 5'd2, 0, 0, 1);
        run_n("R5", 15, 0, 0, 1);
        // R5 write timed onto a pulse cycle while another is pending
        tick("R5", 1'b1, 5'd6, 0, 0, 1);
        while (!clk_en_o) tick("R5", 1'b0, 5'd0, 0, 0, 1);
        tick("R5", 1'b1, 5'd4, 0, 0, 1);
        run_n("R5", 20, 0, 0, 1);
        // R6 demand drops
        run_n("R6", 4, 0, 0, 0);
        // R7 forced running without requests
        run_n("R7", 10, 1, 0, 0);
        // R9 power-down while running is held off
        run_n("R9", 6, 0, 1, 1);
        run_n("R9", 3, 0, 1, 0);
        // R10 off: demand does not restart
        run_n("R10", 5, 0, 1, 1);
        // R11 write while off
        tick("R11", 1'b1, 5'd4, 0, 1, 1);
        run_n("R11", 2, 0, 1, 1);
        // R10 leave power-down, restart from zero
        run_n("R10", 12, 0, 0, 1);
        // R11 write while gated
        run_n("R11", 2, 0, 0, 0);
        tick("R11", 1'b1, 5'd7, 0, 0, 0);
        run_n("R11", 2, 0, 0, 0);
        run_n("R2", 16, 0, 0, 1);
        @(negedge clk_src);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule